// File: doc/BRIEF.md
# Partitioned Narrow-Lane SIMD ALU

This block treats each 64-bit operand as a packed vector of small unsigned values and applies one operation to every element in the same cycle. The word is cut into ten 6-bit lanes, each able to hold one base-64 digit index (0 to 63), plus a 4-bit remainder lane at the top. Every lane has its own adder, and no carry ever leaves a lane. Each lane reports its own carry or borrow as a flag bit.

A producer presents two operand words, a 2-bit opcode and a valid strobe. One registered stage later the packed result, the 11-bit lane flag vector and an output valid appear. When no valid input arrives, the registered result and flags keep their last values. Software-visible state, decode beyond the opcode, and any encoding to or from text live outside this block.

Top module: `lane_simd_alu`

## Requirements
- R1: Lane k (k = 0..9) occupies operand and result bits [6k+5:6k]. The remainder lane occupies bits [63:60]. Each lane is computed only from the same bit range of the two operands.
- R2: Opcode 2'b00 (add) gives, in every lane, (A + B) modulo 2^width. A carry out of one lane never changes any other lane.
- R3: For add, a lane's flag is 1 exactly when the unsigned sum of that lane overflows its width.
- R4: Opcode 2'b01 (subtract) gives, in every lane, (A - B) modulo 2^width, computed independently per lane.
- R5: For subtract, a lane's flag is 1 exactly when that lane's A is less than its B, read as unsigned numbers (a borrow).
- R6: Opcode 2'b10 gives the bitwise AND of the operands, and opcode 2'b11 gives the bitwise OR. For both, every flag bit is 0.
- R7: out_valid is 1 on the clock edge after an edge with in_valid = 1, and 0 after an edge with in_valid = 0. Result and flags for an operation appear with that same single cycle of latency.
- R8: While rst_n is low, out_valid and every flag bit are 0.
- R9: On an edge where in_valid is 0, result and lane_flag keep their previous values.
- R10: Flag bit k belongs to 6-bit lane k, and flag bit 10 belongs to the 4-bit remainder lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 AND, 11 OR |
| opnd_a | input | 64 | First packed operand |
| opnd_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 64 | Packed per-lane result |
| lane_flag | output | 11 | Per-lane carry (add) or borrow (subtract) flags |

## Verification
A carry that leaks across a lane boundary, or a lost per-lane carry injection, corrupts the neighbouring lane's result one cycle after the offending operation. The all-ones-plus-one and boundary subtraction patterns are chosen to expose exactly this. A swapped or misplaced flag bit appears at the flag output in the same cycle as the result. A broken hold enable shows up as a changed result on the first idle cycle after a valid one. Because every clock is compared against the reference model, any such fault is reported at the first cycle it reaches the ports.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

endpackage

// File: rtl/lane_slice.sv
module lane_slice
  import lane_alu_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y,
  output logic           flag
);

  logic          is_sub;
  logic [W-1:0]  b_eff;
  logic [W:0]    sum;

  // Per-lane inversion and +1 injection for subtract; carry stays local.
  always_comb begin
    is_sub = (op == OP_SUB);
    b_eff  = is_sub ? ~b : b;
    sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
  end

  always_comb begin
    unique case (op)
      OP_ADD: begin y = sum[W-1:0]; flag = sum[W];  end
      OP_SUB: begin y = sum[W-1:0]; flag = ~sum[W]; end
      OP_AND: begin y = a & b;      flag = 1'b0;    end
      default: begin y = a | b;     flag = 1'b0;    end
    endcase
  end

endmodule

// File: rtl/lane_array.sv
module lane_array
  import lane_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 6,
  localparam int unsigned NUM_FULL  = DATA_W / LANE_W,
  localparam int unsigned REM_W     = DATA_W - NUM_FULL * LANE_W,
  localparam int unsigned NUM_LANES = NUM_FULL + ((REM_W > 0) ? 1 : 0)
) (
  input  alu_op_e              op,
  input  logic [DATA_W-1:0]    a,
  input  logic [DATA_W-1:0]    b,
  output logic [DATA_W-1:0]    y,
  output logic [NUM_LANES-1:0] flags
);

  for (genvar k = 0; k < NUM_FULL; k++) begin : g_full
    lane_slice #(.W(LANE_W)) u_lane (
      .op   (op),
      .a    (a[k*LANE_W +: LANE_W]),
      .b    (b[k*LANE_W +: LANE_W]),
      .y    (y[k*LANE_W +: LANE_W]),
      .flag (flags[k])
    );
  end

  if (REM_W > 0) begin : g_rem
    lane_slice #(.W(REM_W)) u_lane (
      .op   (op),
      .a    (a[DATA_W-1 -: REM_W]),
      .b    (b[DATA_W-1 -: REM_W]),
      .y    (y[DATA_W-1 -: REM_W]),
      .flag (flags[NUM_LANES-1])
    );
  end

endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned FLAG_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] y_in,
  input  logic [FLAG_W-1:0] f_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] y_q,
  output logic [FLAG_W-1:0] f_q
);

  logic              valid_d;
  logic [DATA_W-1:0] y_d;
  logic [FLAG_W-1:0] f_d;
  logic              load_en;

  always_comb begin
    load_en = in_valid;
    valid_d = in_valid;
    y_d     = load_en ? y_in : y_q;
    f_d     = load_en ? f_in : f_q;
  end

  // Control and flags are reset; the data word is not.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      f_q       <= '0;
    end else begin
      out_valid <= valid_d;
      f_q       <= f_d;
    end
  end

  always_ff @(posedge clk) begin
    y_q <= y_d;
  end

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(y_q) && $stable(f_q)))
    else $error("R9 hold violated");

endmodule

// File: rtl/lane_simd_alu.sv
module lane_simd_alu
  import lane_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 6,
  localparam int unsigned NUM_FULL  = DATA_W / LANE_W,
  localparam int unsigned REM_W     = DATA_W - NUM_FULL * LANE_W,
  localparam int unsigned NUM_LANES = NUM_FULL + ((REM_W > 0) ? 1 : 0)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           op,
  input  logic [DATA_W-1:0]    opnd_a,
  input  logic [DATA_W-1:0]    opnd_b,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    result,
  output logic [NUM_LANES-1:0] lane_flag
);

  alu_op_e               op_e;
  logic [DATA_W-1:0]     y_comb;
  logic [NUM_LANES-1:0]  f_comb;

  assign op_e = alu_op_e'(op);

  lane_array #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lanes (
    .op    (op_e),
    .a     (opnd_a),
    .b     (opnd_b),
    .y     (y_comb),
    .flags (f_comb)
  );

  alu_out_stage #(.DATA_W(DATA_W), .FLAG_W(NUM_LANES)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .y_in      (y_comb),
    .f_in      (f_comb),
    .out_valid (out_valid),
    .y_q       (result),
    .f_q       (lane_flag)
  );

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid)
    else $error("R7 valid latency");

  a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid)
    else $error("R7 idle latency");

  a_r6_logic_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[1]) |=> (lane_flag == '0))
    else $error("R6 flags not zero");

  a_r2_lane0_add: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b00) |=>
      (result[LANE_W-1:0] == LANE_W'($past(opnd_a[LANE_W-1:0]) + $past(opnd_b[LANE_W-1:0]))))
    else $error("R2 lane0 add");

  a_r5_lane0_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b01) |=>
      (lane_flag[0] == ($past(opnd_a[LANE_W-1:0]) < $past(opnd_b[LANE_W-1:0]))))
    else $error("R5 lane0 borrow");

endmodule

// File: tb/lane_simd_alu_tb.sv
module lane_simd_alu_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic [63:0] opnd_a;
  logic [63:0] opnd_b;
  logic        out_valid;
  logic [63:0] result;
  logic [10:0] lane_flag;

  int errors;
  int checks;
  bit done;

  logic        exp_valid;
  logic [63:0] exp_res;
  logic [10:0] exp_flag;
  bit          res_known;
  logic [31:0] seed;

  lane_simd_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .lane_flag(lane_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural model: per-lane integer arithmetic.
  task automatic model(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] r, output logic [10:0] f);
    r = '0;
    f = '0;
    for (int k = 0; k < 11; k++) begin
      int w;
      int lo;
      int av;
      int bv;
      int rv;
      int m;
      w  = (k < 10) ? 6 : 4;
      lo = 6 * k;
      m  = (1 << w) - 1;
      av = int'((a >> lo) & 64'(m));
      bv = int'((b >> lo) & 64'(m));
      case (o)
        2'b00: begin rv = (av + bv) & m; f[k] = (av + bv) > m; end
        2'b01: begin rv = (av - bv) & m; f[k] = av < bv; end
        2'b10: begin rv = av & bv; f[k] = 1'b0; end
        default: begin rv = av | bv; f[k] = 1'b0; end
      endcase
      r = r | (64'(rv) << lo);
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_res(input logic [1:0] o);
    case (o)
      2'b00: return "R2 add result";
      2'b01: return "R4 sub result";
      default: return "R6 logic result";
    endcase
  endfunction

  function automatic string tag_flag(input logic [1:0] o);
    case (o)
      2'b00: return "R3 R10 add flags";
      2'b01: return "R5 R10 sub flags";
      default: return "R6 logic flags";
    endcase
  endfunction

  logic [1:0] last_op;

  // One cycle: drive at negedge, let the posedge latch, compare at the next negedge.
  task automatic step(input logic v, input logic [1:0] o, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    logic [10:0] f;
    in_valid = v; op = o; opnd_a = a; opnd_b = b;
    @(posedge clk);
    @(negedge clk);
    model(o, a, b, r, f);
    exp_valid = v;
    if (v) begin
      exp_res = r; exp_flag = f; res_known = 1'b1; last_op = o;
    end
    check("R7 out_valid", 64'(out_valid), 64'(exp_valid));
    if (res_known) begin
      check(v ? tag_res(o) : "R9 result hold", result, exp_res);
      check(v ? tag_flag(o) : "R9 flag hold", 64'(lane_flag), 64'(exp_flag));
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  initial begin
    errors = 0; checks = 0; done = 0; res_known = 0; seed = 32'h1234_5678;
    rst_n = 1'b0; in_valid = 1'b0; op = 2'b00; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", 64'(out_valid), 64'd0);
    check("R8 reset flags", 64'(lane_flag), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: every lane all-ones plus one; no carry may cross a boundary.
    step(1'b1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1041_0410_4104_1041);
    check("R2 R1 no cross-lane carry", result, 64'h0);
    check("R3 R10 every lane carries", 64'(lane_flag), 64'h7FF);
    // R10: only the remainder lane overflows.
    step(1'b1, 2'b00, 64'hF000_0000_0000_0000, 64'h1000_0000_0000_0001);
    check("R10 top-lane flag bit", 64'(lane_flag), 64'h400);
    // R1: only lane 3 overflows (bits 23:18).
    step(1'b1, 2'b00, 64'(6'h3F) << 18, 64'(6'h01) << 18);
    check("R1 R10 lane3 flag", 64'(lane_flag), 64'h008);
    // R4 R5: zero minus one per lane borrows everywhere without crossing.
    step(1'b1, 2'b01, 64'h0, 64'h1041_0410_4104_1041);
    check("R4 per-lane wrap", result, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R5 all lanes borrow", 64'(lane_flag), 64'h7FF);
    // R5 equality: no borrow.
    step(1'b1, 2'b01, 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567);
    check("R5 equal no borrow", 64'(lane_flag), 64'h0);
    // R6
    step(1'b1, 2'b10, 64'hF0F0_AAAA_5555_0F0F, 64'hFF00_CCCC_3333_FFFF);
    step(1'b1, 2'b11, 64'hF0F0_AAAA_5555_0F0F, 64'hFF00_CCCC_3333_FFFF);
    // R9: idle cycles with garbage inputs keep outputs.
    step(1'b1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1'b0, 2'b01, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
    step(1'b0, 2'b10, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);

    for (int i = 0; i < 200; i++) begin
      logic [63:0] a;
      logic [63:0] b;
      logic [1:0]  o;
      seed = nxt(seed); a[63:32] = seed;
      seed = nxt(seed); a[31:0]  = seed;
      seed = nxt(seed); b[63:32] = seed;
      seed = nxt(seed); b[31:0]  = seed;
      seed = nxt(seed); o = seed[17:16];
      step(seed[20:18] != 3'd0, o, a, b);
    end

    // R8 again: asynchronous reset mid-run clears valid and flags.
    step(1'b1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    #1 rst_n = 1'b0;
    #1;
    check("R8 async reset valid", 64'(out_valid), 64'd0);
    check("R8 async reset flags", 64'(lane_flag), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule